// File: doc/BRIEF.md
# Relocatable Dual-Port Banked Scratchpad SRAM

This block is an on-chip scratchpad memory that sits on the processor's local bus. It also offers a second port to another bus master, such as a DMA engine. The memory spans a window of 2^WIN_BITS bytes, which is 64 KB by default. A configuration register holds the window's upper address bits and an enable flag, so software can place the window on any window-aligned boundary of the 32-bit address space. Each port decodes its own requests against that register and raises a hit flag for addresses inside the window.

The storage is two physical banks of longwords. Address bit 2 picks the bank, so consecutive longwords alternate between the banks. When the two ports touch different banks, both are served in the same cycle. When they touch the same bank, the processor wins and the second master sees its ready signal low.

Accesses may be byte, 16-bit or 32-bit, with big-endian lane order. Write data and read data are right-justified. Read data from the memory is flagged non-cacheable. The block also merges the result of a parallel cache lookup, so that a hit in the scratchpad replaces the cache's data.

Top module: `sram_scratch`

## Requirements
- R1: After reset the window enable is clear and no request hits. Writing the configuration register (`cfg_we`) takes effect from the next cycle. From then on a request hits exactly when the enable is set and addr[31:WIN_BITS] equals the stored base.
- R2: A processor-port request that hits and is aligned is accepted in its own cycle, with no stall. A read returns `c_rvalid` and its data one cycle later. A write is visible to any later read.
- R3: Size codes are 0 = byte, 1 = 16-bit, 2 = 32-bit. Within a longword, byte offset 0 occupies bits [31:24] and offset 3 occupies bits [7:0]. A 16-bit item at offset 0 occupies bits [31:16]. Write data and read data are right-justified on the port.
- R4: A 16-bit request with addr[0]=1, a 32-bit request with addr[1:0]!=0, or size code 3 that hits raises the port's error flag in the same cycle. It writes nothing and produces no read-valid.
- R5: Address bit 2 selects the bank. A processor access and a second-port access to different banks are both served in the same cycle, with `d_ready` high.
- R6: When both ports make valid hits to the same bank in one cycle, the processor access proceeds. `d_ready` is low for that cycle. The second master holds its request, and the held request is served once the conflict is gone.
- R7: `fetch_rdata` carries the scratchpad read data in a cycle where `c_rvalid` is high. In every other cycle it carries `cache_rdata`.
- R8: `c_nocache` is high in exactly the cycles where the processor port returns scratchpad read data.
- R9: A request outside the window writes nothing and produces no read-valid. A second-port request that misses is never stalled.
- R10: After the base is moved, the same storage answers at the new base and the old window misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the window configuration |
| cfg_base | input | 32-WIN_BITS | New window base (upper address bits) |
| cfg_valid | input | 1 | New window enable |
| c_req | input | 1 | Processor request |
| c_we | input | 1 | Processor write (1) or read (0) |
| c_size | input | 2 | Processor access size code |
| c_addr | input | 32 | Processor byte address |
| c_wdata | input | 32 | Processor write data, right-justified |
| c_hit | output | 1 | Processor request falls in the window |
| c_err | output | 1 | Processor request misaligned |
| c_rvalid | output | 1 | Processor read data valid |
| c_rdata | output | 32 | Processor read data, right-justified |
| c_nocache | output | 1 | Returned data must not be cached |
| cache_rdata | input | 32 | Data from the parallel cache lookup |
| fetch_rdata | output | 32 | Merged fetch data |
| d_req | input | 1 | Second-master request |
| d_we | input | 1 | Second-master write |
| d_size | input | 2 | Second-master size code |
| d_addr | input | 32 | Second-master byte address |
| d_wdata | input | 32 | Second-master write data |
| d_ready | output | 1 | Second-master request accepted this cycle |
| d_hit | output | 1 | Second-master request in window |
| d_err | output | 1 | Second-master request misaligned |
| d_rvalid | output | 1 | Second-master read data valid |
| d_rdata | output | 32 | Second-master read data |

## Verification
The bench sweeps every longword of a small window through one port and reads each back through the other. It then walks every byte and 16-bit lane, so a little-endian lane order or a bank-bit slip shows up as swapped bytes or aliased words. It targets same-bank collisions, where a design that let the second master through would drop or corrupt the processor access. It also targets different-bank pairs, where a design that serialises needlessly would drop `d_ready`. Misaligned, out-of-window and disabled-window requests are all tried: a faulty design would write through them or return stray read-valids. A relocation test catches a base compare that is stale or uses the wrong bits.

// File: rtl/sram_scratch_pkg.sv
`timescale 1ns/1ps
package sram_scratch_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  // Alignment rule per access size
  function automatic logic is_misaligned(input logic [1:0] size, input logic [1:0] off);
    case (size)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return off[0];
      SZ_WORD: return off != 2'd0;
      default: return 1'b1;
    endcase
  endfunction

  // Byte-lane enables, lane 3 = bits [31:24] = lowest byte address
  function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] off);
    case (size)
      SZ_BYTE: return 4'b1000 >> off;
      SZ_HALF: return off[1] ? 4'b0011 : 4'b1100;
      SZ_WORD: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  // Replicate right-justified data onto every lane it may occupy
  function automatic logic [31:0] place_data(input logic [1:0] size, input logic [31:0] data);
    case (size)
      SZ_BYTE: return {4{data[7:0]}};
      SZ_HALF: return {2{data[15:0]}};
      default: return data;
    endcase
  endfunction

  // Pull the addressed item out of a longword and right-justify it
  function automatic logic [31:0] extract_data(input logic [1:0] size, input logic [1:0] off,
                                               input logic [31:0] word);
    logic [31:0] r;
    r = 32'd0;
    case (size)
      SZ_BYTE: begin
        case (off)
          2'd0: r[7:0] = word[31:24];
          2'd1: r[7:0] = word[23:16];
          2'd2: r[7:0] = word[15:8];
          default: r[7:0] = word[7:0];
        endcase
      end
      SZ_HALF: r[15:0] = off[1] ? word[15:0] : word[31:16];
      default: r = word;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_scratch_decode.sv
`timescale 1ns/1ps
module sram_scratch_decode
  import sram_scratch_pkg::*;
#(
  parameter int WIN_BITS = 16,
  localparam int BASE_W  = 32 - WIN_BITS,
  localparam int IDX_W   = WIN_BITS - 3
) (
  input  logic              req,
  input  logic [31:0]       addr,
  input  logic [1:0]        size,
  input  logic [BASE_W-1:0] base,
  input  logic              base_valid,
  output logic              hit,
  output logic              err,
  output logic              go,
  output logic              bank,
  output logic [IDX_W-1:0]  idx,
  output logic [1:0]        off
);
  always_comb begin
    hit  = req && base_valid && (addr[31:WIN_BITS] == base);
    err  = hit && is_misaligned(size, addr[1:0]);
    go   = hit && !err;
    bank = addr[2];
    idx  = addr[WIN_BITS-1:3];
    off  = addr[1:0];
  end
endmodule

// File: rtl/sram_scratch_arb.sv
`timescale 1ns/1ps
module sram_scratch_arb (
  input  logic c_go,
  input  logic c_bank,
  input  logic d_req,
  input  logic d_go,
  input  logic d_bank,
  output logic conflict,
  output logic d_ready,
  output logic d_grant
);
  always_comb begin
    conflict = c_go && d_go && (c_bank == d_bank);
    d_ready  = d_req && !conflict;
    d_grant  = d_go && !conflict;
  end
endmodule

// File: rtl/sram_scratch_bank.sv
`timescale 1ns/1ps
module sram_scratch_bank #(
  parameter int IDX_W = 13,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int l = 0; l < 4; l++) begin
        if (be[l]) mem[idx][8*l +: 8] <= wdata[8*l +: 8];
      end
    end
    if (en && !we) rdata <= mem[idx];
  end
endmodule

// File: rtl/sram_scratch.sv
`timescale 1ns/1ps
module sram_scratch
  import sram_scratch_pkg::*;
#(
  parameter int WIN_BITS = 16,
  localparam int BASE_W  = 32 - WIN_BITS,
  localparam int IDX_W   = WIN_BITS - 3,
  localparam int NBANK   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              cfg_valid,
  input  logic              c_req,
  input  logic              c_we,
  input  logic [1:0]        c_size,
  input  logic [31:0]       c_addr,
  input  logic [31:0]       c_wdata,
  output logic              c_hit,
  output logic              c_err,
  output logic              c_rvalid,
  output logic [31:0]       c_rdata,
  output logic              c_nocache,
  input  logic [31:0]       cache_rdata,
  output logic [31:0]       fetch_rdata,
  input  logic              d_req,
  input  logic              d_we,
  input  logic [1:0]        d_size,
  input  logic [31:0]       d_addr,
  input  logic [31:0]       d_wdata,
  output logic              d_ready,
  output logic              d_hit,
  output logic              d_err,
  output logic              d_rvalid,
  output logic [31:0]       d_rdata
);
  // Window configuration
  logic [BASE_W-1:0] base_q;
  logic              base_valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q       <= '0;
      base_valid_q <= 1'b0;
    end else if (cfg_we) begin
      base_q       <= cfg_base;
      base_valid_q <= cfg_valid;
    end
  end

  // Per-port decode, named for the checker
  logic             c_go, c_bank, d_go, d_bank;
  logic [IDX_W-1:0] c_idx, d_idx;
  logic [1:0]       c_off, d_off;

  sram_scratch_decode #(.WIN_BITS(WIN_BITS)) u_cdec (
    .req(c_req), .addr(c_addr), .size(c_size), .base(base_q), .base_valid(base_valid_q),
    .hit(c_hit), .err(c_err), .go(c_go), .bank(c_bank), .idx(c_idx), .off(c_off)
  );

  sram_scratch_decode #(.WIN_BITS(WIN_BITS)) u_ddec (
    .req(d_req), .addr(d_addr), .size(d_size), .base(base_q), .base_valid(base_valid_q),
    .hit(d_hit), .err(d_err), .go(d_go), .bank(d_bank), .idx(d_idx), .off(d_off)
  );

  // Bank arbitration: processor has fixed priority
  logic conflict, d_grant;

  sram_scratch_arb u_arb (
    .c_go(c_go), .c_bank(c_bank), .d_req(d_req), .d_go(d_go), .d_bank(d_bank),
    .conflict(conflict), .d_ready(d_ready), .d_grant(d_grant)
  );

  // Write-side lane steering
  logic [3:0]  c_be, d_be;
  logic [31:0] c_wlane, d_wlane;

  always_comb begin
    c_be    = lane_mask(c_size, c_off);
    d_be    = lane_mask(d_size, d_off);
    c_wlane = place_data(c_size, c_wdata);
    d_wlane = place_data(d_size, d_wdata);
  end

  // Bank array
  logic [31:0] bank_rd [NBANK];

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    logic             sel_c, sel_d, b_en, b_we;
    logic [IDX_W-1:0] b_idx;
    logic [3:0]       b_be;
    logic [31:0]      b_wd;

    always_comb begin
      sel_c = c_go && (c_bank == 1'(k));
      sel_d = d_grant && (d_bank == 1'(k));
      b_en  = sel_c || sel_d;
      b_we  = sel_c ? c_we    : d_we;
      b_idx = sel_c ? c_idx   : d_idx;
      b_be  = sel_c ? c_be    : d_be;
      b_wd  = sel_c ? c_wlane : d_wlane;
    end

    sram_scratch_bank #(.IDX_W(IDX_W)) u_bank (
      .clk(clk), .en(b_en), .we(b_we), .idx(b_idx), .be(b_be),
      .wdata(b_wd), .rdata(bank_rd[k])
    );
  end

  // Read-response pipeline stage
  logic       c_rd_q, d_rd_q, c_bank_q, d_bank_q;
  logic [1:0] c_size_q, d_size_q, c_off_q, d_off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_rd_q <= 1'b0;
      d_rd_q <= 1'b0;
    end else begin
      c_rd_q <= c_go && !c_we;
      d_rd_q <= d_grant && !d_we;
    end
  end

  always_ff @(posedge clk) begin
    c_bank_q <= c_bank;
    c_size_q <= c_size;
    c_off_q  <= c_off;
    d_bank_q <= d_bank;
    d_size_q <= d_size;
    d_off_q  <= d_off;
  end

  always_comb begin
    c_rvalid    = c_rd_q;
    d_rvalid    = d_rd_q;
    c_nocache   = c_rd_q;
    c_rdata     = c_rd_q ? extract_data(c_size_q, c_off_q, bank_rd[c_bank_q]) : 32'd0;
    d_rdata     = d_rd_q ? extract_data(d_size_q, d_off_q, bank_rd[d_bank_q]) : 32'd0;
    fetch_rdata = c_rd_q ? c_rdata : cache_rdata;
  end
endmodule

// File: rtl/sram_scratch_chk.sv
`timescale 1ns/1ps
module sram_scratch_chk (
  input logic clk,
  input logic rst_n,
  input logic base_valid_q,
  input logic c_hit,
  input logic c_err,
  input logic c_go,
  input logic c_we,
  input logic c_bank,
  input logic c_rvalid,
  input logic d_req,
  input logic d_hit,
  input logic d_go,
  input logic d_bank,
  input logic d_ready,
  input logic d_rvalid
);
  // R1
  no_hit_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !base_valid_q |-> (!c_hit && !d_hit));

  // R2
  cpu_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_go && !c_we) |=> c_rvalid);

  // R4
  misalign_no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_err |=> !c_rvalid);

  // R5
  split_bank_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_go && d_go && (c_bank != d_bank)) |-> d_ready);

  // R6
  stall_only_on_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_ready) |-> (c_go && d_go && (c_bank == d_bank)));

  // R9
  miss_no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_hit) |=> !d_rvalid);
endmodule

bind sram_scratch sram_scratch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .base_valid_q(base_valid_q),
  .c_hit(c_hit), .c_err(c_err), .c_go(c_go), .c_we(c_we), .c_bank(c_bank),
  .c_rvalid(c_rvalid), .d_req(d_req), .d_hit(d_hit), .d_go(d_go),
  .d_bank(d_bank), .d_ready(d_ready), .d_rvalid(d_rvalid)
);

// File: tb/tb_sram_scratch.sv
`timescale 1ns/1ps
module tb_sram_scratch;
  localparam int WIN = 8;
  localparam int BW  = 32 - WIN;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_we, cfg_valid;
  logic [BW-1:0] cfg_base;
  logic c_req, c_we, d_req, d_we;
  logic [1:0] c_size, d_size;
  logic [31:0] c_addr, c_wdata, d_addr, d_wdata, cache_rdata;
  logic c_hit, c_err, c_rvalid, c_nocache, d_ready, d_hit, d_err, d_rvalid;
  logic [31:0] c_rdata, d_rdata, fetch_rdata;

  sram_scratch #(.WIN_BITS(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_valid(cfg_valid),
    .c_req(c_req), .c_we(c_we), .c_size(c_size), .c_addr(c_addr), .c_wdata(c_wdata),
    .c_hit(c_hit), .c_err(c_err), .c_rvalid(c_rvalid), .c_rdata(c_rdata),
    .c_nocache(c_nocache), .cache_rdata(cache_rdata), .fetch_rdata(fetch_rdata),
    .d_req(d_req), .d_we(d_we), .d_size(d_size), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_ready(d_ready), .d_hit(d_hit), .d_err(d_err), .d_rvalid(d_rvalid), .d_rdata(d_rdata)
  );

  int nchk = 0, nfail = 0;
  logic [7:0] refm [256];
  logic [BW-1:0] base;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [1:0] sz, input logic [7:0] a);
    case (sz)
      2'd0: return {24'd0, refm[a]};
      2'd1: return {16'd0, refm[a], refm[a+8'd1]};
      default: return {refm[a], refm[a+8'd1], refm[a+8'd2], refm[a+8'd3]};
    endcase
  endfunction

  task automatic ref_wr(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d);
    case (sz)
      2'd0: refm[a] = d[7:0];
      2'd1: begin refm[a] = d[15:8]; refm[a+8'd1] = d[7:0]; end
      default: begin
        refm[a] = d[31:24]; refm[a+8'd1] = d[23:16];
        refm[a+8'd2] = d[15:8]; refm[a+8'd3] = d[7:0];
      end
    endcase
  endtask

  task automatic op(input bit dp, input bit we, input logic [1:0] sz, input logic [31:0] a,
                    input logic [31:0] wd, output logic hit, output logic err,
                    output logic rv, output logic [31:0] rd);
    if (dp) begin d_req = 1; d_we = we; d_size = sz; d_addr = a; d_wdata = wd; end
    else    begin c_req = 1; c_we = we; c_size = sz; c_addr = a; c_wdata = wd; end
    #5;
    hit = dp ? d_hit : c_hit;
    err = dp ? d_err : c_err;
    @(posedge clk); #1;
    rv = dp ? d_rvalid : c_rvalid;
    rd = dp ? d_rdata : c_rdata;
    c_req = 0; d_req = 0;
  endtask

  task automatic set_cfg(input logic [BW-1:0] b, input logic v);
    cfg_we = 1; cfg_base = b; cfg_valid = v;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog (all requirements) got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic h, e, v;
    logic [31:0] rd;
    rst_n = 0; cfg_we = 0; cfg_valid = 0; cfg_base = '0;
    c_req = 0; c_we = 0; c_size = 0; c_addr = 0; c_wdata = 0;
    d_req = 0; d_we = 0; d_size = 0; d_addr = 0; d_wdata = 0;
    cache_rdata = 32'hDEADBEEF;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;

    // R1: reset state, window disabled
    chk("R1 reset rvalid", {31'd0, c_rvalid}, 32'd0);
    op(0, 0, 2'd2, 32'h0000_0000, 0, h, e, v, rd);
    chk("R1 no hit after reset", {31'd0, h}, 32'd0);
    chk("R1 no rvalid after reset", {31'd0, v}, 32'd0);

    base = 24'h00A5C3;
    set_cfg(base, 1'b1);

    // R2: fill every longword via processor, read back via second port
    for (int i = 0; i < 64; i++) begin
      logic [31:0] d;
      d = (i * 32'h0103_0507) ^ 32'hA500_0000;
      op(0, 1, 2'd2, {base, 8'(i*4)}, d, h, e, v, rd);
      chk("R2 cpu write hit", {31'd0, h}, 32'd1);
      ref_wr(2'd2, 8'(i*4), d);
    end
    for (int i = 0; i < 64; i++) begin
      op(1, 0, 2'd2, {base, 8'(i*4)}, 0, h, e, v, rd);
      chk("R2 readback valid", {31'd0, v}, 32'd1);
      chk("R2 readback data", rd, exp_rd(2'd2, 8'(i*4)));
    end

    // R3: byte writes in every lane, big-endian assembly
    for (int o = 0; o < 4; o++) begin
      op(1, 1, 2'd0, {base, 8'(20 + o)}, 32'hFFFF_FF10 + 32'(o), h, e, v, rd);
      ref_wr(2'd0, 8'(20 + o), 32'h10 + 32'(o));
    end
    op(0, 0, 2'd2, {base, 8'd20}, 0, h, e, v, rd);
    chk("R3 byte lanes big-endian", rd, 32'h1011_1213);
    for (int a = 0; a < 256; a++) begin
      op(0, 0, 2'd0, {base, 8'(a)}, 0, h, e, v, rd);
      chk("R3 byte read", rd, exp_rd(2'd0, 8'(a)));
    end
    op(0, 1, 2'd1, {base, 8'd30}, 32'hABCD_7E5A, h, e, v, rd);
    ref_wr(2'd1, 8'd30, 32'h7E5A);
    op(1, 1, 2'd1, {base, 8'd28}, 32'h0000_C001, h, e, v, rd);
    ref_wr(2'd1, 8'd28, 32'hC001);
    op(0, 0, 2'd2, {base, 8'd28}, 0, h, e, v, rd);
    chk("R3 halfword placement", rd, 32'hC001_7E5A);
    for (int a = 0; a < 256; a += 2) begin
      op(1, 0, 2'd1, {base, 8'(a)}, 0, h, e, v, rd);
      chk("R3 half read", rd, exp_rd(2'd1, 8'(a)));
    end

    // R4: misaligned requests flag error, write nothing, no rvalid
    op(0, 1, 2'd1, {base, 8'd41}, 32'h1111_1111, h, e, v, rd);
    chk("R4 half odd err", {31'd0, e}, 32'd1);
    op(0, 1, 2'd2, {base, 8'd42}, 32'h2222_2222, h, e, v, rd);
    chk("R4 word off2 err", {31'd0, e}, 32'd1);
    op(1, 1, 2'd3, {base, 8'd40}, 32'h3333_3333, h, e, v, rd);
    chk("R4 size3 err", {31'd0, e}, 32'd1);
    op(0, 0, 2'd2, {base, 8'd43}, 0, h, e, v, rd);
    chk("R4 misaligned read no rvalid", {31'd0, v}, 32'd0);
    op(0, 0, 2'd2, {base, 8'd40}, 0, h, e, v, rd);
    chk("R4 no write from misaligned", rd, exp_rd(2'd2, 8'd40));

    // R5: different banks in parallel
    c_req = 1; c_we = 0; c_size = 2'd2; c_addr = {base, 8'd0};
    d_req = 1; d_we = 0; d_size = 2'd2; d_addr = {base, 8'd4};
    #5;
    chk("R5 split banks ready", {31'd0, d_ready}, 32'd1);
    @(posedge clk); #1;
    chk("R5 cpu data", c_rdata, exp_rd(2'd2, 8'd0));
    chk("R5 dma rvalid", {31'd0, d_rvalid}, 32'd1);
    chk("R5 dma data", d_rdata, exp_rd(2'd2, 8'd4));
    c_req = 0; d_req = 0;

    // R6: same bank clash, processor wins, DMA retried
    c_req = 1; c_we = 0; c_size = 2'd2; c_addr = {base, 8'd16};
    d_req = 1; d_we = 1; d_size = 2'd2; d_addr = {base, 8'd8}; d_wdata = 32'h5EED_F00D;
    #5;
    chk("R6 dma stalled", {31'd0, d_ready}, 32'd0);
    @(posedge clk); #1;
    chk("R6 cpu served", c_rdata, exp_rd(2'd2, 8'd16));
    c_req = 0;
    #5;
    chk("R6 dma ready after clash", {31'd0, d_ready}, 32'd1);
    @(posedge clk); #1;
    d_req = 0;
    ref_wr(2'd2, 8'd8, 32'h5EED_F00D);
    op(0, 0, 2'd2, {base, 8'd8}, 0, h, e, v, rd);
    chk("R6 retried write landed", rd, 32'h5EED_F00D);

    // R7/R8: fetch merge and non-cacheable flag
    c_req = 1; c_we = 0; c_size = 2'd2; c_addr = {base, 8'd12};
    @(posedge clk); #1;
    chk("R7 fetch from scratchpad", fetch_rdata, exp_rd(2'd2, 8'd12));
    chk("R8 nocache on hit", {31'd0, c_nocache}, 32'd1);
    c_addr = {base + 24'd1, 8'd12};
    @(posedge clk); #1;
    chk("R7 fetch from cache on miss", fetch_rdata, 32'hDEADBEEF);
    chk("R8 nocache low on miss", {31'd0, c_nocache}, 32'd0);
    c_req = 0;

    // R9: misses write nothing, never stall
    op(0, 1, 2'd2, {base + 24'd1, 8'd16}, 32'hFFFF_FFFF, h, e, v, rd);
    chk("R9 miss hit flag", {31'd0, h}, 32'd0);
    op(0, 0, 2'd2, {base, 8'd16}, 0, h, e, v, rd);
    chk("R9 miss no write", rd, exp_rd(2'd2, 8'd16));
    c_req = 1; c_we = 0; c_size = 2'd2; c_addr = {base, 8'd0};
    d_req = 1; d_we = 0; d_size = 2'd2; d_addr = {base - 24'd1, 8'd0};
    #5;
    chk("R9 miss not stalled", {31'd0, d_ready}, 32'd1);
    @(posedge clk); #1;
    chk("R9 miss no rvalid", {31'd0, d_rvalid}, 32'd0);
    c_req = 0; d_req = 0;

    // R10: relocate
    set_cfg(24'h000001, 1'b1);
    op(0, 0, 2'd2, {base, 8'd24}, 0, h, e, v, rd);
    chk("R10 old window misses", {31'd0, h}, 32'd0);
    op(1, 0, 2'd2, {24'h000001, 8'd24}, 0, h, e, v, rd);
    chk("R10 new window data", rd, exp_rd(2'd2, 8'd24));

    // R1: disable clears hits
    set_cfg(24'h000001, 1'b0);
    op(0, 0, 2'd2, {24'h000001, 8'd24}, 0, h, e, v, rd);
    chk("R1 disabled no hit", {31'd0, h}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule